// File: doc/BRIEF.md
# Interrupt Distributor Enable and Pending State Bank

This block keeps the enable and pending state of every interrupt in a multi-CPU interrupt distributor and changes it through byte-wide writes. A write names an offset, a data byte and the CPU that issued it. The offset picks one of four operations: set enable, clear enable, set pending or clear pending. It also picks a group of eight consecutive interrupts, and each set data bit acts on its own interrupt. Zero bits leave their interrupts alone.

Interrupts numbered below 32 are private to each CPU. A write to one of them touches only the requesting CPU's copy. Interrupts from 32 upward are shared. Enabling a shared interrupt enables it for every CPU. Setting a shared interrupt pending marks it on the CPUs in that interrupt's own target mask. When an interrupt is level-sensitive and its input is high, enabling it makes it pending in the same update. Writes that fall outside the implemented range, or into the active-state window, are refused and raise an error flag for one cycle.

Top module: `irq_dist_bank`

## Requirements
- R1: A write at offsets 0x100–0x17F sets enables. Byte n covers interrupts 8n..8n+7, and data bit i acts on interrupt 8n+i. Zero data bits change nothing.
- R2: A write at offsets 0x180–0x1FF clears the enable of each interrupt whose data bit is 1.
- R3: A write at offsets 0x200–0x27F sets a shared interrupt k pending on exactly the CPUs in its own target mask `tgt_mask[k*NCPU +: NCPU]`. Each bit of the byte uses its own interrupt's mask.
- R4: A write at offsets 0x280–0x2FF clears the selected interrupt's pending state on all CPUs, private interrupts included.
- R5: For interrupts below 32, set enable, clear enable and set pending change only the bit of the requesting CPU `wr_cpu`. For interrupts 32 and up, set enable and clear enable act on all CPUs.
- R6: A set-enable write to a byte covering interrupts 0–15 enables all eight interrupts of that byte, whatever the data. A clear-enable write to interrupts 0–15 has no effect.
- R7: If a set-enable write enables interrupt k while `edge_mode[k]`=0 (level) and `lvl_in[k]`=1, then k also becomes pending in the same update. For k<32 it becomes pending on the requesting CPU. For k≥32 it becomes pending on the CPUs in its target mask. With `edge_mode[k]`=1 no pending state is added.
- R8: A write is rejected when any of these holds:
  - it falls in offsets 0x300–0x3FF;
  - it falls in one of the four enable/pending regions and its first interrupt is at or above NIRQ;
  - it falls in one of the four enable/pending regions and `wr_cpu` ≥ NCPU.
  A rejected write changes no state, and `bad_acc` is 1 in the cycle after it. Offsets below 0x100 are ignored and raise no error.
- R9: State bit (cpu c, interrupt k) appears at index c*NIRQ+k of `en_vec` and `pend_vec`. Updates take effect at the clock edge that samples the write. A synchronous reset clears all enable state, all pending state and `bad_acc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_off | input | 10 | Byte offset of the write |
| wr_data | input | 8 | Write data, one bit per interrupt |
| wr_cpu | input | 3 | Id of the requesting CPU |
| lvl_in | input | NIRQ | Level input of each interrupt |
| edge_mode | input | NIRQ | 1 = edge-triggered, 0 = level-sensitive |
| tgt_mask | input | NIRQ*NCPU | CPU target mask of each interrupt |
| en_vec | output | NCPU*NIRQ | Enable state, index c*NIRQ+k |
| pend_vec | output | NCPU*NIRQ | Pending state, index c*NIRQ+k |
| bad_acc | output | 1 | Rejected write seen in the previous cycle |

## Verification
Set-pending is tried with several bits in one byte whose interrupts have different target masks. This separates a per-bit mask lookup from one that reuses the first interrupt's mask. The same private interrupt is enabled and disabled from different CPUs, and the checks tell a banked update from a global one. Data bytes of all-zero and all-one are written to the always-on interrupts, which separates the forced-enable rule from a plain write. Level-sensitive interrupts with a high input are compared against an edge-triggered interrupt, so pending-on-enable shows up only where it should.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int unsigned OFF_W           = 10;
  localparam int unsigned CPU_ID_W        = 3;
  localparam int unsigned MAX_CPU         = 8;
  localparam int unsigned INTERNAL_LIMIT  = 32;
  localparam int unsigned ALWAYS_ON_LIMIT = 16;

  typedef enum logic [2:0] {
    RG_IGNORE = 3'd0,
    RG_SET_EN = 3'd1,
    RG_CLR_EN = 3'd2,
    RG_SET_PD = 3'd3,
    RG_CLR_PD = 3'd4,
    RG_ACTIVE = 3'd5
  } region_e;

  // Offset window -> operation; 128-byte windows selected by off[9:7]
  function automatic region_e region_of(input logic [OFF_W-1:0] off);
    case (off[9:7])
      3'd2:       return RG_SET_EN;
      3'd3:       return RG_CLR_EN;
      3'd4:       return RG_SET_PD;
      3'd5:       return RG_CLR_PD;
      3'd6, 3'd7: return RG_ACTIVE;
      default:    return RG_IGNORE;
    endcase
  endfunction

  // Number of the first interrupt covered by the addressed byte
  function automatic logic [OFF_W-1:0] first_irq(input logic [OFF_W-1:0] off);
    return {off[6:0], 3'b000};
  endfunction

  // CPUs whose enable copy a write touches
  function automatic logic [MAX_CPU-1:0] bank_mask(input logic internal,
                                                   input logic [MAX_CPU-1:0] req);
    return internal ? req : {MAX_CPU{1'b1}};
  endfunction

  // CPUs that receive a pending mark from a set operation
  function automatic logic [MAX_CPU-1:0] mark_mask(input logic internal,
                                                   input logic [MAX_CPU-1:0] req,
                                                   input logic [MAX_CPU-1:0] tgt);
    return internal ? req : tgt;
  endfunction

endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
  import irq_dist_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64
) (
  input  logic                wr_en,
  input  logic [OFF_W-1:0]    wr_off,
  input  logic [7:0]          wr_data,
  input  logic [CPU_ID_W-1:0] wr_cpu,
  output logic [NIRQ-1:0]     sel_set_en,
  output logic [NIRQ-1:0]     sel_clr_en,
  output logic [NIRQ-1:0]     sel_set_pd,
  output logic [NIRQ-1:0]     sel_clr_pd,
  output logic [NCPU-1:0]     req_oh,
  output logic                wr_bad
);

  region_e          region;
  logic [OFF_W-1:0] base;
  logic             state_region;
  logic             in_range;
  logic             cpu_ok;
  logic             accept;

  always_comb begin
    region       = region_of(wr_off);
    base         = first_irq(wr_off);
    state_region = (region == RG_SET_EN) || (region == RG_CLR_EN) ||
                   (region == RG_SET_PD) || (region == RG_CLR_PD);
    in_range     = base < OFF_W'(NIRQ);
    cpu_ok       = {1'b0, wr_cpu} < (CPU_ID_W + 1)'(NCPU);
    wr_bad       = wr_en && ((region == RG_ACTIVE) ||
                             (state_region && (!in_range || !cpu_ok)));
    accept       = wr_en && state_region && in_range && cpu_ok;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_req
    assign req_oh[c] = (wr_cpu == CPU_ID_W'(c));
  end

  for (genvar k = 0; k < NIRQ; k++) begin : g_sel
    localparam int BYTE_IDX = k / 8;
    localparam int BIT_IDX  = k % 8;
    localparam bit ALWAYS_ON = k < ALWAYS_ON_LIMIT;
    logic hit;
    logic bit_on;
    assign hit    = accept && (wr_off[6:0] == 7'(BYTE_IDX));
    assign bit_on = wr_data[BIT_IDX];
    assign sel_set_en[k] = hit && (region == RG_SET_EN) && (bit_on || ALWAYS_ON);
    assign sel_clr_en[k] = hit && (region == RG_CLR_EN) && bit_on && !ALWAYS_ON;
    assign sel_set_pd[k] = hit && (region == RG_SET_PD) && bit_on;
    assign sel_clr_pd[k] = hit && (region == RG_CLR_PD) && bit_on;
  end

endmodule

// File: rtl/irq_state_slice.sv
module irq_state_slice
  import irq_dist_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int IDX  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic            set_pd,
  input  logic            clr_pd,
  input  logic [NCPU-1:0] req_oh,
  input  logic [NCPU-1:0] tgt,
  input  logic            lvl,
  input  logic            edge_m,
  output logic [NCPU-1:0] en_q,
  output logic [NCPU-1:0] pd_q
);

  localparam bit INTERNAL = IDX < INTERNAL_LIMIT;

  logic [NCPU-1:0] cm;
  logic [NCPU-1:0] pmask;
  logic            lvl_fire;
  logic            mark;

  assign cm       = NCPU'(bank_mask(INTERNAL, MAX_CPU'(req_oh)));
  assign pmask    = NCPU'(mark_mask(INTERNAL, MAX_CPU'(req_oh), MAX_CPU'(tgt)));
  assign lvl_fire = set_en && !edge_m && lvl;
  assign mark     = set_pd || lvl_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      pd_q <= '0;
    end else begin
      if (set_en)      en_q <= en_q | cm;
      else if (clr_en) en_q <= en_q & ~cm;
      if (clr_pd)      pd_q <= '0;
      else if (mark)   pd_q <= pd_q | pmask;
    end
  end

  // R4: clear pending empties every CPU copy
  a_r4_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_pd |=> (pd_q == '0));

  // R5: private enable only moves the requester's bit
  a_r5_banked_enable: assert property (@(posedge clk) disable iff (rst)
    (INTERNAL && (set_en || clr_en)) |=>
      ((en_q & ~$past(req_oh)) == ($past(en_q) & ~$past(req_oh))));

  // R7: level-high enable marks pending on the mark mask
  a_r7_level_pending: assert property (@(posedge clk) disable iff (rst)
    lvl_fire |=> ((pd_q & $past(pmask)) == $past(pmask)));

  // R6: always-on interrupts never see a clear-enable
  a_r6_no_clear: assert property (@(posedge clk) disable iff (rst)
    (IDX < ALWAYS_ON_LIMIT) |-> !clr_en);

endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
  import irq_dist_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int NIRQ = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [9:0]           wr_off,
  input  logic [7:0]           wr_data,
  input  logic [2:0]           wr_cpu,
  input  logic [NIRQ-1:0]      lvl_in,
  input  logic [NIRQ-1:0]      edge_mode,
  input  logic [NIRQ*NCPU-1:0] tgt_mask,
  output logic [NCPU*NIRQ-1:0] en_vec,
  output logic [NCPU*NIRQ-1:0] pend_vec,
  output logic                 bad_acc
);

  logic [NIRQ-1:0] sel_set_en;
  logic [NIRQ-1:0] sel_clr_en;
  logic [NIRQ-1:0] sel_set_pd;
  logic [NIRQ-1:0] sel_clr_pd;
  logic [NCPU-1:0] req_oh;
  logic            wr_bad;
  logic            bad_q;

  irq_wr_decode #(.NCPU(NCPU), .NIRQ(NIRQ)) u_decode (
    .wr_en     (wr_en),
    .wr_off    (wr_off),
    .wr_data   (wr_data),
    .wr_cpu    (wr_cpu),
    .sel_set_en(sel_set_en),
    .sel_clr_en(sel_clr_en),
    .sel_set_pd(sel_set_pd),
    .sel_clr_pd(sel_clr_pd),
    .req_oh    (req_oh),
    .wr_bad    (wr_bad)
  );

  for (genvar k = 0; k < NIRQ; k++) begin : g_irq
    logic [NCPU-1:0] en_q;
    logic [NCPU-1:0] pd_q;
    irq_state_slice #(.NCPU(NCPU), .IDX(k)) u_slice (
      .clk   (clk),
      .rst   (rst),
      .set_en(sel_set_en[k]),
      .clr_en(sel_clr_en[k]),
      .set_pd(sel_set_pd[k]),
      .clr_pd(sel_clr_pd[k]),
      .req_oh(req_oh),
      .tgt   (tgt_mask[k*NCPU +: NCPU]),
      .lvl   (lvl_in[k]),
      .edge_m(edge_mode[k]),
      .en_q  (en_q),
      .pd_q  (pd_q)
    );
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
      assign en_vec[c*NIRQ + k]   = en_q[c];
      assign pend_vec[c*NIRQ + k] = pd_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bad_q <= 1'b0;
    else     bad_q <= wr_bad;
  end
  assign bad_acc = bad_q;

  // R8: a refused write leaves all state untouched and flags next cycle
  a_r8_refused_frozen: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> ($stable(en_vec) && $stable(pend_vec) && bad_acc));

  // R8: active-state window is always refused
  a_r8_active_window: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_off[9:8] == 2'b11)) |=> bad_acc);

  // R1: one write drives at most one operation
  a_r1_single_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({|sel_set_en, |sel_clr_en, |sel_set_pd, |sel_clr_pd}));

endmodule

// File: tb/irq_dist_bank_bench.sv
module irq_dist_bank_bench;

  localparam int NCPU = 4;
  localparam int NIRQ = 64;
  localparam int NTBL = 23;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wr_en = 1'b0;
  logic [9:0]           wr_off = '0;
  logic [7:0]           wr_data = '0;
  logic [2:0]           wr_cpu = '0;
  logic [NIRQ-1:0]      lvl_in;
  logic [NIRQ-1:0]      edge_mode;
  logic [NIRQ*NCPU-1:0] tgt_mask;
  logic [NCPU*NIRQ-1:0] en_vec;
  logic [NCPU*NIRQ-1:0] pend_vec;
  logic                 bad_acc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 20 ns period, 50 MHz

  irq_dist_bank #(.NCPU(NCPU), .NIRQ(NIRQ)) u_irq_dist_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .wr_cpu(wr_cpu), .lvl_in(lvl_in), .edge_mode(edge_mode), .tgt_mask(tgt_mask),
    .en_vec(en_vec), .pend_vec(pend_vec), .bad_acc(bad_acc)
  );

  // Target of shared interrupt k: one CPU (k mod 4), or all four when k mod 4 == 3
  function automatic logic [3:0] tgt_of(input int k);
    return (k % 4 == 3) ? 4'hF : (4'h1 << (k % 4));
  endfunction

  function automatic logic [3:0] view(input bit pend, input int k);
    logic [3:0] v;
    for (int c = 0; c < NCPU; c++)
      v[c] = pend ? pend_vec[c*NIRQ + k] : en_vec[c*NIRQ + k];
    return v;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] off, input logic [7:0] data,
                          input logic [2:0] cpu);
    @(negedge clk);
    wr_en = 1'b1; wr_off = off; wr_data = data; wr_cpu = cpu;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Fields: req[38:35] off[34:25] data[24:17] cpu[16:14] pend[13] irq[12:5] exp[4:1] err[0]
  localparam logic [38:0] TBL [NTBL] = '{
    {4'd1, 10'h105, 8'h05, 3'd0, 1'b0, 8'd40, 4'hF, 1'b0},  // R1 shared enable, all CPUs
    {4'd1, 10'h105, 8'h00, 3'd1, 1'b0, 8'd42, 4'hF, 1'b0},  // R1 zero bits keep state
    {4'd2, 10'h185, 8'h01, 3'd2, 1'b0, 8'd40, 4'h0, 1'b0},  // R2 clear enable
    {4'd2, 10'h185, 8'h04, 3'd0, 1'b0, 8'd42, 4'h0, 1'b0},  // R2
    {4'd3, 10'h205, 8'h0E, 3'd0, 1'b1, 8'd41, 4'h2, 1'b0},  // R3 own target of 41
    {4'd3, 10'h205, 8'h00, 3'd0, 1'b1, 8'd43, 4'hF, 1'b0},  // R3 own target of 43
    {4'd3, 10'h205, 8'h00, 3'd0, 1'b1, 8'd42, 4'h4, 1'b0},  // R3 own target of 42
    {4'd4, 10'h285, 8'h08, 3'd1, 1'b1, 8'd43, 4'h0, 1'b0},  // R4 clear pending
    {4'd5, 10'h102, 8'h02, 3'd2, 1'b0, 8'd17, 4'h4, 1'b0},  // R5 banked enable
    {4'd5, 10'h102, 8'h02, 3'd1, 1'b0, 8'd17, 4'h6, 1'b0},  // R5
    {4'd5, 10'h182, 8'h02, 3'd2, 1'b0, 8'd17, 4'h2, 1'b0},  // R5 banked clear
    {4'd5, 10'h202, 8'h08, 3'd3, 1'b1, 8'd19, 4'h8, 1'b0},  // R5 banked pending
    {4'd4, 10'h282, 8'h08, 3'd0, 1'b1, 8'd19, 4'h0, 1'b0},  // R4 clears all copies
    {4'd6, 10'h100, 8'h00, 3'd1, 1'b0, 8'd3,  4'h2, 1'b0},  // R6 forced enable
    {4'd6, 10'h100, 8'h00, 3'd1, 1'b0, 8'd7,  4'h2, 1'b0},  // R6
    {4'd6, 10'h180, 8'hFF, 3'd1, 1'b0, 8'd3,  4'h2, 1'b0},  // R6 clear ignored
    {4'd7, 10'h102, 8'h10, 3'd3, 1'b1, 8'd20, 4'h8, 1'b0},  // R7 private level
    {4'd7, 10'h106, 8'h04, 3'd0, 1'b1, 8'd50, 4'h4, 1'b0},  // R7 shared level
    {4'd7, 10'h106, 8'h08, 3'd0, 1'b1, 8'd51, 4'h0, 1'b0},  // R7 edge: no pending
    {4'd8, 10'h108, 8'hFF, 3'd0, 1'b0, 8'd40, 4'h0, 1'b1},  // R8 beyond NIRQ
    {4'd8, 10'h300, 8'h01, 3'd0, 1'b1, 8'd50, 4'h4, 1'b1},  // R8 active window
    {4'd8, 10'h100, 8'hFF, 3'd5, 1'b0, 8'd0,  4'h2, 1'b1},  // R8 CPU id out of range
    {4'd8, 10'h010, 8'hFF, 3'd0, 1'b0, 8'd0,  4'h2, 1'b0}   // R8 low offsets ignored
  };

  initial begin
    for (int k = 0; k < NIRQ; k++) begin
      tgt_mask[k*NCPU +: NCPU] = tgt_of(k);
      lvl_in[k]    = (k == 20) || (k == 50);
      edge_mode[k] = !((k == 20) || (k == 50));
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9", "reset en", 32'(|en_vec), 32'd0);
    check("R9", "reset pend", 32'(|pend_vec), 32'd0);
    check("R9", "reset bad", 32'(bad_acc), 32'd0);

    for (int t = 0; t < NTBL; t++) begin
      logic [38:0] e;
      string rq;
      e = TBL[t];
      rq = $sformatf("R%0d row %0d", e[38:35], t);
      do_write(e[34:25], e[24:17], e[16:14]);
      check(rq, e[13] ? "pend" : "en", 32'(view(e[13], int'(e[12:5]))), 32'(e[4:1]));
      check(rq, "bad_acc", 32'(bad_acc), 32'(e[0]));
    end

    // R9: change appears only after the sampling edge
    @(negedge clk);
    wr_en = 1'b1; wr_off = 10'h107; wr_data = 8'h10; wr_cpu = 3'd0;
    #5;
    check("R9", "en60 before edge", 32'(view(1'b0, 60)), 32'h0);
    @(negedge clk);
    wr_en = 1'b0;
    check("R9", "en60 after edge", 32'(view(1'b0, 60)), 32'hF);
    check("R9", "bad flag one cycle", 32'(bad_acc), 32'd0);

    // R8: flag lasts one cycle only
    do_write(10'h3FF, 8'hFF, 3'd0);
    check("R8", "bad set", 32'(bad_acc), 32'd1);
    @(negedge clk);
    check("R8", "bad cleared", 32'(bad_acc), 32'd0);

    // R9: reset in mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "mid reset en", 32'(|en_vec), 32'd0);
    check("R9", "mid reset pend", 32'(|pend_vec), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule